// File: doc/BRIEF.md
# Four-Bit Function-Selectable ALU Slice

A purely combinational arithmetic/logic slice working on two four-bit operands. A four-bit select code and a mode input together pick one of 32 operations. In logic mode each result bit is a two-input function of the matching operand bits, with no carries between bits. In arithmetic mode the select code picks one of 16 word operations, and carries propagate across the slice. Operands and results are active high. The carry input and the carry output are active low.

Slices chain in ripple fashion by wiring one slice's carry output to the next slice's carry input. Group propagate and generate outputs, both active low, let an external lookahead unit combine several slices. These two outputs depend only on the operands and the select code. An equality flag goes high when the result is all ones. With the subtract code and no incoming carry, that flag reports operand equality.

Top module: `slice_alu`

## Requirements
- R1: With logic_mode_i high, f_o bit i depends only on a_i[i] and b_i[i]. The select codes (sel_i[3:0]) give these functions: 0000 NOT A, 0011 constant 0, 0110 A XOR B, 1001 XNOR, 1011 AND, 1100 constant 1, 1110 OR, 1111 A. All 16 two-input functions are reachable.
- R2: With logic_mode_i low, f_o = ((A | X) + (A & Y) + c) mod 16. sel_i[1:0] picks X: 00 gives 0, 01 gives B, 10 gives NOT B, 11 gives all ones. sel_i[3:2] picks Y: 00 gives 0, 01 gives NOT B, 10 gives B, 11 gives all ones.
- R3: The carry input is active low. carry_ni = 0 makes c = 1 and adds one to the arithmetic result. carry_ni = 1 adds nothing.
- R4: carry_no is low exactly when (A | X) + (A & Y) + c is 16 or more.
- R5: Code 0110 in arithmetic mode gives A-B-1 with carry_ni = 1 and A-B with carry_ni = 0. In that mode, carry_no low means no borrow occurred.
- R6: In arithmetic mode with carry_ni = 1: 1001 gives A+B, 1100 gives A+A (each bit shifted up one place), 0000 gives A, and 1111 gives A-1.
- R7: gen_no is low exactly when (A | X) + (A & Y) is 16 or more. prop_no is low exactly when every bit of (A | X) | (A & Y) is 1. Neither output depends on carry_ni.
- R8: eq_o is high exactly when f_o is all ones. With code 0110, arithmetic mode and carry_ni = 1, it is high exactly when A equals B.
- R9: The carry output satisfies NOT carry_no = NOT gen_no OR (NOT prop_no AND NOT carry_ni), whatever the mode.
- R10: Two slices joined by feeding the low slice's carry_no into the high slice's carry_ni give the same 8-bit sum and carry as one 8-bit adder, for both the add code and the subtract code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 4 | Operand A |
| b_i | input | 4 | Operand B |
| sel_i | input | 4 | Function select code |
| logic_mode_i | input | 1 | High selects bitwise logic, low selects arithmetic |
| carry_ni | input | 1 | Carry input, active low |
| f_o | output | 4 | Result |
| carry_no | output | 1 | Ripple carry output, active low |
| prop_no | output | 1 | Group propagate, active low |
| gen_no | output | 1 | Group generate, active low |
| eq_o | output | 1 | High when the result is all ones |

## Verification
The slice holds no state. A wrong operand term, or a wrong carry link, shows on f_o or carry_no in the same evaluation as the input change that exercises it, so each vector is checked right after it settles. A bad carry link inside the chain affects only some operand pairs, which is why all 32 operations are swept over every operand pair and both carry values. A group propagate or generate output that wrongly depends on the carry input shows as a mismatch with the carry output relation. The ripple pair is swept over all 8-bit operand pairs, which exposes any carry polarity error between slices.

// File: rtl/slice_alu_pkg.sv
package slice_alu_pkg;
  // selection for the OR-combined operand term, indexed by sel[1:0]
  typedef enum logic [1:0] {
    OT_ZERO = 2'b00,
    OT_B    = 2'b01,
    OT_NB   = 2'b10,
    OT_ONES = 2'b11
  } or_term_e;

  // selection for the AND-combined operand term, indexed by sel[3:2]
  typedef enum logic [1:0] {
    AT_ZERO = 2'b00,
    AT_NB   = 2'b01,
    AT_B    = 2'b10,
    AT_ONES = 2'b11
  } and_term_e;
endpackage

// File: rtl/alu_bit_terms.sv
module alu_bit_terms
  import slice_alu_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [3:0]       sel_i,
  output logic [WIDTH-1:0] u_o,   // A | X
  output logic [WIDTH-1:0] v_o    // A & Y
);
  or_term_e  ot;
  and_term_e at;
  assign ot = or_term_e'(sel_i[1:0]);
  assign at = and_term_e'(sel_i[3:2]);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic x_b, y_b;
    always_comb begin
      unique case (ot)
        OT_ZERO: x_b = 1'b0;
        OT_B:    x_b = b_i[i];
        OT_NB:   x_b = ~b_i[i];
        default: x_b = 1'b1;
      endcase
      unique case (at)
        AT_ZERO: y_b = 1'b0;
        AT_NB:   y_b = ~b_i[i];
        AT_B:    y_b = b_i[i];
        default: y_b = 1'b1;
      endcase
    end
    assign u_o[i] = a_i[i] | x_b;
    assign v_o[i] = a_i[i] & y_b;
  end
endmodule

// File: rtl/alu_ripple_chain.sv
module alu_ripple_chain #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] gen_i,
  input  logic [WIDTH-1:0] prop_i,
  input  logic             cin_i,
  output logic [WIDTH:0]   c_o
);
  assign c_o[0] = cin_i;
  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    assign c_o[i+1] = gen_i[i] | (prop_i[i] & c_o[i]);
  end
endmodule

// File: rtl/alu_group_pg.sv
module alu_group_pg #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] gen_i,
  input  logic [WIDTH-1:0] prop_i,
  output logic             grp_gen_o,
  output logic             grp_prop_o
);
  // flattened lookahead: bit i generates and every higher bit propagates
  always_comb begin
    grp_gen_o = 1'b0;
    for (int i = 0; i < WIDTH; i++) begin
      logic term;
      term = gen_i[i];
      for (int j = i + 1; j < WIDTH; j++) term = term & prop_i[j];
      grp_gen_o = grp_gen_o | term;
    end
  end
  assign grp_prop_o = &prop_i;
endmodule

// File: rtl/slice_alu.sv
module slice_alu #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [3:0]       sel_i,
  input  logic             logic_mode_i,
  input  logic             carry_ni,
  output logic [WIDTH-1:0] f_o,
  output logic             carry_no,
  output logic             prop_no,
  output logic             gen_no,
  output logic             eq_o
);
  logic [WIDTH-1:0] u, v, half;
  logic [WIDTH:0]   c;
  logic             grp_gen, grp_prop;

  alu_bit_terms #(.WIDTH(WIDTH)) i_terms (
    .a_i(a_i), .b_i(b_i), .sel_i(sel_i), .u_o(u), .v_o(v)
  );

  // v is a subset of u, so u propagates and v generates
  alu_ripple_chain #(.WIDTH(WIDTH)) i_chain (
    .gen_i(v), .prop_i(u), .cin_i(~carry_ni), .c_o(c)
  );

  alu_group_pg #(.WIDTH(WIDTH)) i_pg (
    .gen_i(v), .prop_i(u), .grp_gen_o(grp_gen), .grp_prop_o(grp_prop)
  );

  assign half     = u & ~v;
  assign f_o      = logic_mode_i ? ~half : (half ^ c[WIDTH-1:0]);
  assign carry_no = ~c[WIDTH];
  assign prop_no  = ~grp_prop;
  assign gen_no   = ~grp_gen;
  assign eq_o     = &f_o;
endmodule

// File: rtl/slice_alu_chk.sv
module slice_alu_chk #(
  parameter int WIDTH = 4
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic [3:0]       sel_i,
  input logic             logic_mode_i,
  input logic             carry_ni,
  input logic [WIDTH-1:0] f_o,
  input logic             carry_no,
  input logic             prop_no,
  input logic             gen_no,
  input logic             eq_o
);
  logic [WIDTH:0] add_ref, sub_ref;
  assign add_ref = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, ~carry_ni};
  assign sub_ref = {1'b0, a_i} + {1'b0, ~b_i} + {{WIDTH{1'b0}}, ~carry_ni};

  always_comb begin
    if (!logic_mode_i && sel_i == 4'b1001)
      AST_ADD_RESULT: assert ({~carry_no, f_o} == add_ref); // R6
    if (!logic_mode_i && sel_i == 4'b0110)
      AST_SUB_BORROW: assert ({~carry_no, f_o} == sub_ref); // R5
    if (logic_mode_i && sel_i == 4'b0110)
      AST_LOGIC_XOR: assert (f_o == (a_i ^ b_i)); // R1
    if (!logic_mode_i && sel_i == 4'b0110 && carry_ni)
      AST_EQ_ON_MATCH: assert (eq_o == (a_i == b_i)); // R8
    AST_CARRY_FROM_PG: assert (~carry_no == (~gen_no | (~prop_no & ~carry_ni))); // R9
  end
endmodule

bind slice_alu slice_alu_chk #(.WIDTH(WIDTH)) i_slice_alu_chk (
  .a_i(a_i), .b_i(b_i), .sel_i(sel_i), .logic_mode_i(logic_mode_i),
  .carry_ni(carry_ni), .f_o(f_o), .carry_no(carry_no), .prop_no(prop_no),
  .gen_no(gen_no), .eq_o(eq_o)
);

// File: tb/test_slice_alu.sv
module test_slice_alu;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic [3:0] a, b, sel, f;
  logic       mode, cn, cout_n, p_n, g_n, eq;

  slice_alu i_slice_alu (
    .a_i(a), .b_i(b), .sel_i(sel), .logic_mode_i(mode), .carry_ni(cn),
    .f_o(f), .carry_no(cout_n), .prop_no(p_n), .gen_no(g_n), .eq_o(eq)
  );

  // 8-bit ripple pair
  logic [7:0] wa, wb, wf;
  logic [3:0] wsel;
  logic       wcn, mid_n, wcout_n, lp, lg, hp, hg, le, he;

  slice_alu i_slice_alu_lo (
    .a_i(wa[3:0]), .b_i(wb[3:0]), .sel_i(wsel), .logic_mode_i(1'b0), .carry_ni(wcn),
    .f_o(wf[3:0]), .carry_no(mid_n), .prop_no(lp), .gen_no(lg), .eq_o(le)
  );
  slice_alu i_slice_alu_hi (
    .a_i(wa[7:4]), .b_i(wb[7:4]), .sel_i(wsel), .logic_mode_i(1'b0), .carry_ni(mid_n),
    .f_o(wf[7:4]), .carry_no(wcout_n), .prop_no(hp), .gen_no(hg), .eq_o(he)
  );

  function automatic logic [3:0] or_term(logic [1:0] s, logic [3:0] bb);
    case (s)
      2'd0: return 4'h0;
      2'd1: return bb;
      2'd2: return ~bb;
      default: return 4'hF;
    endcase
  endfunction

  function automatic logic [3:0] and_term(logic [1:0] s, logic [3:0] bb);
    case (s)
      2'd0: return 4'h0;
      2'd1: return ~bb;
      2'd2: return bb;
      default: return 4'hF;
    endcase
  endfunction

  // packed expectation {f, carry_n, prop_n, gen_n, eq}
  function automatic logic [7:0] model(logic [3:0] aa, logic [3:0] bb, logic [3:0] s,
                                       logic m, logic cin_n);
    logic [3:0] u, v, ff;
    logic [4:0] sum, raw;
    u   = aa | or_term(s[1:0], bb);
    v   = aa & and_term(s[3:2], bb);
    raw = {1'b0, u} + {1'b0, v};
    sum = raw + {4'b0, ~cin_n};
    ff  = m ? ~(u ^ v) : sum[3:0];
    return {ff, ~sum[4], ~(&(u | v)), ~raw[4], &ff};
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s a=%h b=%h sel=%b m=%b cn=%b got=%h exp=%h",
               tag, a, b, sel, mode, cn, got, exp);
    end
  endtask

  task automatic apply(logic [3:0] aa, logic [3:0] bb, logic [3:0] s, logic m, logic c);
    a = aa; b = bb; sel = s; mode = m; cn = c;
    #2;
  endtask

  function automatic logic [7:0] outs();
    return {f, cout_n, p_n, g_n, eq};
  endfunction

  initial begin
    apply(4'h0, 4'h0, 4'h0, 1'b0, 1'b1);
    check("R2 idle", {24'b0, outs()}, {24'b0, 4'h0, 1'b1, 1'b1, 1'b1, 1'b0});

    // directed logic codes (R1)
    apply(4'b1100, 4'b1010, 4'b0000, 1'b1, 1'b1); check("R1 not_a", {28'b0, f}, 32'h3);
    apply(4'b1100, 4'b1010, 4'b0011, 1'b1, 1'b0); check("R1 zero",  {28'b0, f}, 32'h0);
    apply(4'b1100, 4'b1010, 4'b0110, 1'b1, 1'b1); check("R1 xor",   {28'b0, f}, 32'h6);
    apply(4'b1100, 4'b1010, 4'b1001, 1'b1, 1'b1); check("R1 xnor",  {28'b0, f}, 32'h9);
    apply(4'b1100, 4'b1010, 4'b1011, 1'b1, 1'b0); check("R1 and",   {28'b0, f}, 32'h8);
    apply(4'b1100, 4'b1010, 4'b1100, 1'b1, 1'b1); check("R1 one",   {28'b0, f}, 32'hF);
    apply(4'b1100, 4'b1010, 4'b1110, 1'b1, 1'b1); check("R1 or",    {28'b0, f}, 32'hE);
    apply(4'b1100, 4'b1010, 4'b1111, 1'b1, 1'b0); check("R1 pass",  {28'b0, f}, 32'hC);

    // directed arithmetic (R6, R5, R3, R4)
    apply(4'd9, 4'd5, 4'b1001, 1'b0, 1'b1); check("R6 add",  {27'b0, ~cout_n, f}, 32'd14);
    apply(4'd9, 4'd9, 4'b1001, 1'b0, 1'b0); check("R3 R4 add_cin", {27'b0, ~cout_n, f}, 32'd19);
    apply(4'd5, 4'd0, 4'b1100, 1'b0, 1'b1); check("R6 double", {28'b0, f}, 32'd10);
    apply(4'd7, 4'd3, 4'b0000, 1'b0, 1'b1); check("R6 pass_a", {28'b0, f}, 32'd7);
    apply(4'd0, 4'd3, 4'b1111, 1'b0, 1'b1); check("R6 dec", {27'b0, cout_n, f}, 32'h1F);
    apply(4'd6, 4'd6, 4'b0110, 1'b0, 1'b1); check("R8 eq_sub", {31'b0, eq}, 32'd1);
    apply(4'd6, 4'd6, 4'b0110, 1'b0, 1'b0); check("R5 sub_eq", {27'b0, cout_n, f}, 32'h0);
    apply(4'd3, 4'd6, 4'b0110, 1'b0, 1'b0); check("R5 borrow", {27'b0, cout_n, f}, 32'h1D);
    apply(4'd6, 4'd3, 4'b0110, 1'b0, 1'b1); check("R8 ne", {31'b0, eq}, 32'd0);

    // exhaustive single slice (R1 R2 R3 R4 R7 R8 R9)
    for (int s = 0; s < 16; s++)
      for (int m = 0; m < 2; m++)
        for (int x = 0; x < 256; x++)
          for (int ci = 0; ci < 2; ci++) begin
            apply(x[3:0], x[7:4], s[3:0], m[0], ci[0]);
            check("R1 R2 R4 sweep", {24'b0, outs()},
                  {24'b0, model(x[3:0], x[7:4], s[3:0], m[0], ci[0])});
          end

    // carry-in independence of group outputs (R7)
    for (int k = 0; k < 200; k++) begin
      logic [3:0] ra, rb, rs;
      logic [1:0] pg0;
      ra = 4'($urandom); rb = 4'($urandom); rs = 4'($urandom);
      apply(ra, rb, rs, 1'b0, 1'b1);
      pg0 = {p_n, g_n};
      apply(ra, rb, rs, 1'b0, 1'b0);
      check("R7 cin_indep", {30'b0, p_n, g_n}, {30'b0, pg0});
    end

    // ripple pair, exhaustive add and subtract (R10)
    for (int op = 0; op < 2; op++)
      for (int x = 0; x < 65536; x++)
        for (int ci = 0; ci < 2; ci++) begin
          logic [8:0] exp9;
          wa = x[7:0]; wb = x[15:8]; wcn = ci[0];
          wsel = op == 0 ? 4'b1001 : 4'b0110;
          exp9 = op == 0 ? {1'b0, wa} + {1'b0, wb} + {8'b0, ~wcn}
                         : {1'b0, wa} + {1'b0, ~wb} + {8'b0, ~wcn};
          #2;
          n_tests++;
          if ({~wcout_n, wf} !== exp9) begin
            n_fail++;
            $display("FAIL R10 a=%h b=%h sel=%b cn=%b got=%h exp=%h",
                     wa, wb, wsel, wcn, {~wcout_n, wf}, exp9);
          end
        end

    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    process::self().srandom(32'd1234);
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired got=running exp=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule